// File: doc/BRIEF.md
# Channel-Skipping Burst Address Sequencer

This block keeps the register address for a burst transfer on a byte-serial register port. Sixteen data registers hold the results of eight converter channels, one pair per channel: the even address of a pair is the channel's high byte and the odd address is its low byte, so channel k uses addresses 2k and 2k+1. Above the data registers sits a small control region that ends at a status register.

A burst starts with a load of the address taken from the command byte. After that, one advance strobe comes at the end of each completed data byte. In the data region, the address does not step by one. It moves from channel to channel and skips every channel whose bit in the active-channel mask is clear. After the highest active channel it wraps round to the lowest one. The stepping pattern depends on the resolution flag. In 8-bit mode only low bytes are visited. In 10-bit mode the high byte of a channel is followed by its low byte. In the control region the address counts up by one and stops at the status register, so that register can be polled over and over.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low the address output is 0.
- R2: A load whose address is in the data region ($00–$0F) while `mode_10b` is 0 stores that address with bit 0 set to 1. Any other load stores the address unchanged.
- R3: In 8-bit mode, an advance from a data address moves to address 2n+1. Here n is the next active channel found by searching upward and circularly from the current channel plus one. The current channel itself is found last.
- R4: In 10-bit mode, an advance from an even data address (high byte) moves to the odd address of the same channel.
- R5: In 10-bit mode, an advance from an odd data address (low byte) moves to address 2n, where n is the next active channel found by the same circular search as in R3.
- R6: When no active channel lies above the current one, the search wraps round to the lowest-numbered active channel.
- R7: An advance from a data address while the mask is all zero leaves the address unchanged.
- R8: An advance from $10, $11 or $12 adds one. An advance from $13 or any higher address leaves the address unchanged.
- R9: With neither load nor advance asserted, the address holds.
- R10: When load and advance are asserted in the same cycle, the load wins.
- R11: When the current channel is the only active one, an advance from its low byte comes back to the same channel (8-bit mode: the same address; 10-bit mode: its high byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Take `load_addr` as the start address of a burst |
| load_addr | input | 5 | Register address from the command byte |
| advance | input | 1 | One-cycle pulse at the end of each data byte |
| chan_mask | input | 8 | Active-channel mask; bit k enables channel k |
| mode_10b | input | 1 | 1 = 10-bit stepping (high then low byte), 0 = 8-bit (low bytes only) |
| addr_q | output | 5 | Current register address |

## Verification
The assertions expect `load`, `advance`, `mode_10b` and `chan_mask` to be known values at each rising edge. The mask and the mode may change in any cycle, so each landing check uses the mask that was present in the cycle of the advance. The stimulus changes inputs only on the falling clock edge. It mixes directed bursts with random mask, mode, load and advance values over the whole 5-bit address range, including the all-zero mask and single-channel masks. As a result every input combination that the assertions reason about actually occurs.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    STEP_HOLD      = 3'd0,
    STEP_SAME_LOW  = 3'd1,
    STEP_NEXT_LOW  = 3'd2,
    STEP_NEXT_HIGH = 3'd3,
    STEP_CTRL_INC  = 3'd4
  } step_kind_e;
endpackage

// File: rtl/chan_finder.sv
module chan_finder #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   cur_ch,
  output logic              found,
  output logic [CH_W-1:0]   next_ch
);
  // Circular search upward from cur_ch+1; offset NUM_CH is cur_ch itself.
  always_comb begin
    found   = 1'b0;
    next_ch = cur_ch;
    for (int off = NUM_CH; off >= 1; off--) begin
      int j;
      logic [CH_W-1:0] jj;
      j = int'(cur_ch) + off;
      if (j >= NUM_CH) j = j - NUM_CH;
      jj = CH_W'(j);
      if (mask[jj]) begin
        found   = 1'b1;
        next_ch = jj;
      end
    end
  end
endmodule

// File: rtl/step_logic.sv
module step_logic
  import burst_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CTRL_LAST = 5'h13,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode_10b,
  input  logic              any_active,
  input  logic [CH_W-1:0]   next_ch,
  output logic              in_data,
  output step_kind_e        kind,
  output logic [ADDR_W-1:0] next_addr
);
  localparam int PAD_W = ADDR_W - CH_W - 1;

  function automatic logic [ADDR_W-1:0] pair_addr(input logic [CH_W-1:0] ch,
                                                  input logic low);
    return {{PAD_W{1'b0}}, ch, low};
  endfunction

  assign in_data = (addr >> (CH_W + 1)) == '0;

  always_comb begin
    if (!in_data)
      kind = (addr < CTRL_LAST) ? STEP_CTRL_INC : STEP_HOLD;
    else if (!any_active)
      kind = STEP_HOLD;
    else if (mode_10b && !addr[0])
      kind = STEP_SAME_LOW;
    else if (mode_10b)
      kind = STEP_NEXT_HIGH;
    else
      kind = STEP_NEXT_LOW;
  end

  always_comb begin
    unique case (kind)
      STEP_CTRL_INC:  next_addr = addr + ADDR_W'(1);
      STEP_SAME_LOW:  next_addr = {addr[ADDR_W-1:1], 1'b1};
      STEP_NEXT_HIGH: next_addr = pair_addr(next_ch, 1'b0);
      STEP_NEXT_LOW:  next_addr = pair_addr(next_ch, 1'b1);
      default:        next_addr = addr;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CTRL_LAST = 5'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              advance,
  input  logic [NUM_CH-1:0] chan_mask,
  input  logic              mode_10b,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int CH_W = $clog2(NUM_CH);

  logic              any_active;
  logic [CH_W-1:0]   next_ch;
  logic              in_data;
  step_kind_e        kind;
  logic [ADDR_W-1:0] step_addr;
  logic              load_in_data;
  logic [ADDR_W-1:0] load_value;

  chan_finder #(.NUM_CH(NUM_CH)) u_find (
    .mask    (chan_mask),
    .cur_ch  (addr_q[CH_W:1]),
    .found   (any_active),
    .next_ch (next_ch)
  );

  step_logic #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CTRL_LAST(CTRL_LAST)) u_step (
    .addr       (addr_q),
    .mode_10b   (mode_10b),
    .any_active (any_active),
    .next_ch    (next_ch),
    .in_data    (in_data),
    .kind       (kind),
    .next_addr  (step_addr)
  );

  assign load_in_data = (load_addr >> (CH_W + 1)) == '0;
  assign load_value   = (load_in_data && !mode_10b) ? {load_addr[ADDR_W-1:1], 1'b1}
                                                    : load_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (load)    addr_q <= load_value;
    else if (advance) addr_q <= step_addr;
  end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CTRL_LAST = 5'h13,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [ADDR_W-1:0] load_addr,
  input logic              advance,
  input logic [NUM_CH-1:0] chan_mask,
  input logic              mode_10b,
  input logic [ADDR_W-1:0] addr_q,
  input logic              in_data,
  input logic              any_active,
  input step_kind_e        kind
);
  logic [NUM_CH-1:0] mask_q;
  always_ff @(posedge clk) mask_q <= chan_mask;

  logic step_now;
  assign step_now = advance && !load;

  assert_reset_zero_R1: assert property (@(posedge clk) !rst_n |=> addr_q == '0);

  assert_load_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load && !mode_10b && ((load_addr >> (CH_W + 1)) == '0) |=> addr_q[0]);

  assert_load_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load && (mode_10b || ((load_addr >> (CH_W + 1)) != '0)) |=> addr_q == $past(load_addr));

  assert_low_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_now && !mode_10b && in_data && (chan_mask != '0)
    |=> addr_q[0] && mask_q[addr_q[CH_W:1]] && ((addr_q >> (CH_W + 1)) == '0));

  assert_same_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_now && mode_10b && in_data && !addr_q[0] && (chan_mask != '0)
    |=> addr_q == $past(addr_q) + ADDR_W'(1));

  assert_next_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_now && mode_10b && in_data && addr_q[0] && (chan_mask != '0)
    |=> !addr_q[0] && mask_q[addr_q[CH_W:1]]);

  assert_empty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_now && in_data && !any_active |=> $stable(addr_q));

  assert_ctrl_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_now && !in_data && (addr_q < CTRL_LAST) |=> addr_q == $past(addr_q) + ADDR_W'(1));

  assert_ctrl_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_now && (addr_q >= CTRL_LAST) |=> $stable(addr_q));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !advance |=> $stable(addr_q));

  assert_hold_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_now && kind == STEP_HOLD |=> $stable(addr_q));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load && advance |=> addr_q[ADDR_W-1:1] == $past(load_addr[ADDR_W-1:1]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CTRL_LAST(CTRL_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
  .advance(advance), .chan_mask(chan_mask), .mode_10b(mode_10b),
  .addr_q(addr_q), .in_data(in_data), .any_active(any_active), .kind(kind)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [4:0] load_addr = '0;
  logic       advance = 1'b0;
  logic [7:0] chan_mask = '0;
  logic       mode_10b = 1'b0;
  logic [4:0] addr_q;

  int errors = 0;
  int checks = 0;
  int model  = 0;

  always #10 clk = ~clk;

  burst_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
    .advance(advance), .chan_mask(chan_mask), .mode_10b(mode_10b), .addr_q(addr_q)
  );

  function automatic int ref_next(int a, int m, bit m10, output string tag);
    int c;
    tag = "";
    if (a >= 16) begin
      tag = "R8";
      return (a < 19) ? a + 1 : a;
    end
    if (m == 0) begin
      tag = "R7";
      return a;
    end
    c = a / 2;
    if (m10 && (a % 2 == 0)) begin
      tag = "R4";
      return a + 1;
    end
    for (int k = 1; k <= 8; k++) begin
      int n;
      n = (c + k) % 8;
      if (m[n]) begin
        if (n == c)     tag = "R11";
        else if (n < c) tag = m10 ? "R6/R5" : "R6/R3";
        else            tag = m10 ? "R5" : "R3";
        return m10 ? 2 * n : 2 * n + 1;
      end
    end
    return a;
  endfunction

  task automatic check(string tag, int expv);
    checks++;
    if (int'(addr_q) != expv) begin
      errors++;
      $display("FAIL %s addr_q=%0d expected=%0d", tag, addr_q, expv);
    end
  endtask

  // Called at a falling edge; drives one cycle and checks at the next falling edge.
  task automatic step(bit ld, int la, bit adv, int m, bit m10);
    string tag;
    load = ld; load_addr = 5'(la); advance = adv;
    chan_mask = 8'(m); mode_10b = m10;
    if (ld) begin
      tag   = adv ? "R10" : "R2";
      model = (la < 16 && !m10) ? (la | 1) : la;
    end else if (adv) begin
      model = ref_next(model, m, m10, tag);
    end else begin
      tag = "R9";
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, model);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0);
    rst_n = 1'b1;
    model = 0;
    // 8-bit walk with skips and wrap
    step(1, 4, 0, 8'hA5, 0);      // R2: ch2 -> 5
    step(0, 0, 1, 8'hA5, 0);      // R3 -> 11
    step(0, 0, 1, 8'hA5, 0);      // R3 -> 15
    step(0, 0, 1, 8'hA5, 0);      // R6 -> 1
    step(0, 0, 0, 8'hA5, 0);      // R9
    // 10-bit pairs
    step(1, 6, 0, 8'h48, 1);      // R2 keeps 6
    step(0, 0, 1, 8'h48, 1);      // R4 -> 7
    step(0, 0, 1, 8'h48, 1);      // R5 -> 12
    step(0, 0, 1, 8'h48, 1);      // R4 -> 13
    step(0, 0, 1, 8'h48, 1);      // R6 -> 6
    // empty mask
    step(0, 0, 1, 8'h00, 1);      // R7
    step(0, 0, 1, 8'h00, 0);      // R7
    // control region saturation
    step(1, 16, 0, 8'hFF, 0);
    step(0, 0, 1, 8'hFF, 0);      // R8 -> 17
    step(0, 0, 1, 8'hFF, 0);      // R8 -> 18
    step(0, 0, 1, 8'hFF, 0);      // R8 -> 19
    step(0, 0, 1, 8'hFF, 0);      // R8 holds 19
    step(1, 31, 0, 8'hFF, 1);
    step(0, 0, 1, 8'hFF, 1);      // R8 holds 31
    // single active channel
    step(1, 8, 0, 8'h10, 0);      // R2 -> 9
    step(0, 0, 1, 8'h10, 0);      // R11 -> 9
    step(0, 0, 1, 8'h10, 1);      // R11 -> 8
    // load beats advance
    step(1, 2, 1, 8'hFF, 1);      // R10 -> 2
    step(1, 18, 1, 8'hFF, 0);     // R10 -> 18
    // random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 8;
      step(r == 0, $urandom % 32, r != 1, ($urandom % 4 == 0) ? (1 << ($urandom % 8)) : $urandom % 256,
           1'($urandom % 2));
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule